// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out where a single load or store instruction touches memory and what the base register should hold afterwards. It takes a 32-bit base value and an offset. The offset is either a zero-extended immediate, an index register value, or an index register value shifted left by a constant amount. The offset is added to or subtracted from the base. Three indexing modes decide which value goes to memory and whether the base is updated. In offset mode the sum is the address and the base is left alone. In pre-indexed mode the sum is both the address and the new base. In post-indexed mode the untouched base is the address and the sum becomes the new base.

Each accepted request is registered once, so results appear one cycle after the request. The same response cycle also carries the byte-lane enables for a little-endian byte, halfword or word access. For loads, the block pulls the addressed byte or halfword out of the raw memory word and extends it with its sign bit or with zeros. The memory port, register file and multiple-register transfers sit outside.

Top module: `ls_addr_gen`

## Requirements
- R1: While reset is applied and after it ends, until the first request, `rsp_valid`, `wb_en` and `byte_en` are all 0, and `eff_addr` and `wb_value` are 0.
- R2: With `idx_mode` = 0 (offset), `eff_addr` equals base plus or minus offset, `wb_value` equals the same sum, and `wb_en` is 0.
- R3: With `idx_mode` = 1 (pre-indexed), `eff_addr` and `wb_value` both equal base plus or minus offset, and `wb_en` is 1.
- R4: With `idx_mode` = 2 (post-indexed), `eff_addr` equals the unmodified base, `wb_value` equals base plus or minus offset, and `wb_en` is 1.
- R5: `off_sel` picks the offset: 0 gives `imm_off` zero-extended, 1 gives `index`, 2 gives `index` shifted left by `shamt`, and 3 gives `index` unshifted.
- R6: `sub_off` = 1 subtracts the offset from the base, and `sub_off` = 0 adds it.
- R7: Address arithmetic wraps modulo 2^32 and raises no fault.
- R8: A request sampled on a rising edge gives `rsp_valid` = 1 with its results after that edge. In cycles with no request, `rsp_valid` and `wb_en` are 0 and `eff_addr` and `wb_value` keep their last values.
- R9: `acc_size` = 0 (byte) sets exactly one `byte_en` bit, the bit at position `eff_addr[1:0]`.
- R10: `acc_size` = 1 (halfword) sets `byte_en` = 4'b0011 when `eff_addr[1]` = 0, and 4'b1100 when it is 1.
- R11: `acc_size` = 2 or 3 (word) sets `byte_en` = 4'b1111 whatever the low address bits are, and `ld_data` equals `mem_rdata`.
- R12: For a byte access, `ld_data` is bits [8*a+7:8*a] of `mem_rdata`, where a = `eff_addr[1:0]`. For a halfword access, it is bits [16*h+15:16*h], where h = `eff_addr[1]`. The value is sign-extended when the registered `ld_signed` is 1 and zero-extended otherwise.
- R13: `idx_mode` = 3 behaves exactly like offset mode.
- R14: `byte_en` is 0 in every cycle where `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| imm_off | input | 12 | Immediate offset, zero-extended |
| off_sel | input | 2 | Offset source select |
| shamt | input | 5 | Left-shift amount for the index |
| idx_mode | input | 2 | Indexing mode |
| sub_off | input | 1 | 1 subtracts the offset, 0 adds it |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| ld_signed | input | 1 | Sign-extend load data |
| mem_rdata | input | 32 | Raw memory word for the response cycle |
| rsp_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Address sent to memory |
| wb_value | output | 32 | New base register value |
| wb_en | output | 1 | Base register writeback enable |
| byte_en | output | 4 | Little-endian byte-lane enables |
| ld_data | output | 32 | Extended load data |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 12-bit immediate and a 5-bit shift amount. With these values the largest immediate (0xFFF) and the largest shift (31) can both be reached. A shift of 31 moves bit 0 of the index to the top bit, and adding it to a base of 0x80000000 wraps the result to zero. The stimulus also reaches every lane position for bytes and halfwords, both extension polarities, and the reserved select codes for mode and offset source.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    OFS_IMM     = 2'd0,
    OFS_REG     = 2'd1,
    OFS_REG_SHL = 2'd2,
    OFS_RSVD    = 2'd3
  } ofs_src_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsagu_offset_gen.sv
module lsagu_offset_gen
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic [ADDR_W-1:0] index,
  input  logic [IMM_W-1:0]  imm_off,
  input  ofs_src_e          off_sel,
  input  logic [SH_W-1:0]   shamt,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] idx_shl;

  // Zero-extend the immediate; a full-width immediate needs no padding.
  generate
    if (IMM_W < ADDR_W) begin : g_pad
      assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_off};
    end else begin : g_trunc
      assign imm_ext = imm_off[ADDR_W-1:0];
    end
  endgenerate

  assign idx_shl = index << shamt;

  always_comb begin
    unique case (off_sel)
      OFS_IMM:     offset = imm_ext;
      OFS_REG_SHL: offset = idx_shl;
      default:     offset = index;
    endcase
  end
endmodule

// File: rtl/lsagu_addr_calc.sv
module lsagu_addr_calc
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic              sub_off,
  input  idx_mode_e         idx_mode,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] wb_value,
  output logic              wb_en
);
  logic [ADDR_W-1:0] sum;

  // Modulo 2^ADDR_W: carries out of the top bit are dropped.
  assign sum = sub_off ? (base - offset) : (base + offset);

  always_comb begin
    wb_value = sum;
    unique case (idx_mode)
      IDX_PRE: begin
        eff_addr = sum;
        wb_en    = 1'b1;
      end
      IDX_POST: begin
        eff_addr = base;
        wb_en    = 1'b1;
      end
      default: begin
        eff_addr = sum;
        wb_en    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lsagu_lane_unit.sv
module lsagu_lane_unit
  import lsagu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   active,
  input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
  input  acc_size_e              size,
  input  logic                   ld_signed,
  input  logic [DATA_W-1:0]      rdata,
  output logic [DATA_W/8-1:0]    byte_en,
  output logic [DATA_W-1:0]      ld_data
);
  localparam int LANES = DATA_W / 8;
  localparam int LO_W  = $clog2(LANES);
  localparam int HALVES = LANES / 2;

  logic [LANES-1:0] be_byte;
  logic [LANES-1:0] be_half;
  logic [7:0]       sel_byte;
  logic [15:0]      sel_half;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be_byte[g] = (addr_lo == LO_W'(g));
      assign be_half[g] = (addr_lo[LO_W-1:1] == (LO_W-1)'(g / 2));
    end
  endgenerate

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (addr_lo == LO_W'(i)) sel_byte = rdata[8*i +: 8];
    end
  end

  always_comb begin
    sel_half = '0;
    for (int j = 0; j < HALVES; j++) begin
      if (addr_lo[LO_W-1:1] == (LO_W-1)'(j)) sel_half = rdata[16*j +: 16];
    end
  end

  always_comb begin
    if (!active) begin
      byte_en = '0;
    end else begin
      unique case (size)
        SZ_BYTE: byte_en = be_byte;
        SZ_HALF: byte_en = be_half;
        default: byte_en = '1;
      endcase
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: ld_data = {{(DATA_W-8){ld_signed & sel_byte[7]}}, sel_byte};
      SZ_HALF: ld_data = {{(DATA_W-16){ld_signed & sel_half[15]}}, sel_half};
      default: ld_data = rdata;
    endcase
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    base,
  input  logic [ADDR_W-1:0]    index,
  input  logic [IMM_W-1:0]     imm_off,
  input  logic [1:0]           off_sel,
  input  logic [SH_W-1:0]      shamt,
  input  logic [1:0]           idx_mode,
  input  logic                 sub_off,
  input  logic [1:0]           acc_size,
  input  logic                 ld_signed,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 rsp_valid,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic [ADDR_W-1:0]    wb_value,
  output logic                 wb_en,
  output logic [DATA_W/8-1:0]  byte_en,
  output logic [DATA_W-1:0]    ld_data
);
  localparam int LANES = DATA_W / 8;
  localparam int LO_W  = $clog2(LANES);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] ea_c, wb_c;
  logic              wben_c;

  lsagu_offset_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_ofs (
    .index   (index),
    .imm_off (imm_off),
    .off_sel (ofs_src_e'(off_sel)),
    .shamt   (shamt),
    .offset  (offset)
  );

  lsagu_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .base     (base),
    .offset   (offset),
    .sub_off  (sub_off),
    .idx_mode (idx_mode_e'(idx_mode)),
    .eff_addr (ea_c),
    .wb_value (wb_c),
    .wb_en    (wben_c)
  );

  // Response stage: next-state logic then registers, enabled by req_valid.
  logic              vld_d, vld_q;
  logic [ADDR_W-1:0] ea_d, ea_q, wb_d, wb_q;
  logic              wben_d, wben_q;
  acc_size_e         size_d, size_q;
  logic              sgn_d, sgn_q;
  logic              cap_en;

  assign cap_en = req_valid;

  always_comb begin
    vld_d  = req_valid;
    ea_d   = ea_q;
    wb_d   = wb_q;
    wben_d = 1'b0;
    size_d = size_q;
    sgn_d  = sgn_q;
    if (cap_en) begin
      ea_d   = ea_c;
      wb_d   = wb_c;
      wben_d = wben_c;
      size_d = acc_size_e'(acc_size);
      sgn_d  = ld_signed;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      vld_q  <= 1'b0;
      ea_q   <= '0;
      wb_q   <= '0;
      wben_q <= 1'b0;
      size_q <= SZ_BYTE;
      sgn_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      ea_q   <= ea_d;
      wb_q   <= wb_d;
      wben_q <= wben_d;
      size_q <= size_d;
      sgn_q  <= sgn_d;
    end
  end

  lsagu_lane_unit #(.DATA_W(DATA_W)) u_lane (
    .active    (vld_q),
    .addr_lo   (ea_q[LO_W-1:0]),
    .size      (size_q),
    .ld_signed (sgn_q),
    .rdata     (mem_rdata),
    .byte_en   (byte_en),
    .ld_data   (ld_data)
  );

  assign rsp_valid = vld_q;
  assign eff_addr  = ea_q;
  assign wb_value  = wb_q;
  assign wb_en     = wben_q;
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [ADDR_W-1:0]   base,
  input logic [1:0]          idx_mode,
  input logic [1:0]          acc_size,
  input logic                rsp_valid,
  input logic [ADDR_W-1:0]   eff_addr,
  input logic [ADDR_W-1:0]   wb_value,
  input logic                wb_en,
  input logic [DATA_W/8-1:0] byte_en
);
  // R2 R13
  no_wb_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (idx_mode == 2'd0 || idx_mode == 2'd3)) |=> (rsp_valid && !wb_en));

  // R3
  pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd1) |=> (wb_en && eff_addr == wb_value));

  // R4
  post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd2) |=> (wb_en && eff_addr == $past(base)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !wb_en && $stable(eff_addr) && $stable(wb_value)));

  // R9
  byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size == 2'd0) |=> ($countones(byte_en) == 1));

  // R10
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size == 2'd1) |=> ($countones(byte_en) == 2));

  // R11
  word_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size[1]) |=> (byte_en == '1));

  // R14
  be_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (byte_en == '0));
endmodule

bind ls_addr_gen ls_addr_gen_chk #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .base      (base),
  .idx_mode  (idx_mode),
  .acc_size  (acc_size),
  .rsp_valid (rsp_valid),
  .eff_addr  (eff_addr),
  .wb_value  (wb_value),
  .wb_en     (wb_en),
  .byte_en   (byte_en)
);

// File: tb/ls_addr_gen_tb.sv
module ls_addr_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] base, index, mem_rdata;
  logic [11:0] imm_off;
  logic [1:0]  off_sel, idx_mode, acc_size;
  logic [4:0]  shamt;
  logic        sub_off, ld_signed;
  logic        rsp_valid, wb_en;
  logic [31:0] eff_addr, wb_value, ld_data;
  logic [3:0]  byte_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ls_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base(base), .index(index),
    .imm_off(imm_off), .off_sel(off_sel), .shamt(shamt), .idx_mode(idx_mode),
    .sub_off(sub_off), .acc_size(acc_size), .ld_signed(ld_signed),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .eff_addr(eff_addr),
    .wb_value(wb_value), .wb_en(wb_en), .byte_en(byte_en), .ld_data(ld_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] ea;
    logic [31:0] wb;
    logic        wben;
    logic [3:0]  be;
    logic [1:0]  size;
    logic        sgn;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;
  bit   have_last = 0;
  bit   mon_on = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_ld(logic [31:0] rd, logic [31:0] a, logic [1:0] sz, logic s);
    logic [31:0] sh;
    if (sz == 2'd0) begin
      sh = rd >> (8 * a[1:0]);
      return s ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]};
    end else if (sz == 2'd1) begin
      sh = rd >> (16 * a[1]);
      return s ? {{16{sh[15]}}, sh[15:0]} : {16'd0, sh[15:0]};
    end
    return rd;
  endfunction

  // Driver: computes the expected result from the requirements and pushes it.
  task automatic drive(input logic [31:0] b, input logic [31:0] ix, input logic [11:0] im,
                       input logic [1:0] os, input logic [4:0] sa, input logic [1:0] md,
                       input logic sb_, input logic [1:0] sz, input logic sg,
                       input logic [31:0] rd, input string tag);
    exp_t e;
    logic [31:0] off, sum;
    @(negedge clk);
    case (os)
      2'd0: off = {20'd0, im};          // R5 immediate
      2'd2: off = ix << sa;             // R5 shifted index
      default: off = ix;                // R5 index, code 3 unshifted
    endcase
    sum = sb_ ? b - off : b + off;      // R6 R7
    e.wb   = sum;
    e.ea   = (md == 2'd2) ? b : sum;    // R4
    e.wben = (md == 2'd1) || (md == 2'd2);
    if (sz == 2'd0)      e.be = 4'b0001 << e.ea[1:0];
    else if (sz == 2'd1) e.be = e.ea[1] ? 4'b1100 : 4'b0011;
    else                 e.be = 4'b1111;
    e.size = sz; e.sgn = sg; e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1; base = b; index = ix; imm_off = im; off_sel = os; shamt = sa;
    idx_mode = md; sub_off = sb_; acc_size = sz; ld_signed = sg; mem_rdata = rd;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected rsp_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(eff_addr == e.ea, {e.tag, " eff_addr"}, eff_addr, e.ea);
          chk(wb_value == e.wb, {e.tag, " wb_value"}, wb_value, e.wb);
          chk(wb_en == e.wben, {e.tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e.wben});
          chk(byte_en == e.be, {e.tag, " byte_en"}, {28'd0, byte_en}, {28'd0, e.be});
          chk(ld_data == model_ld(mem_rdata, e.ea, e.size, e.sgn), {e.tag, " ld_data"},
              ld_data, model_ld(mem_rdata, e.ea, e.size, e.sgn));
          last = e; have_last = 1;
        end
      end else if (have_last) begin
        chk(eff_addr == last.ea && wb_value == last.wb && !wb_en && byte_en == 4'd0,
            "R8 R14 idle hold", eff_addr, last.ea);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; base = '0; index = '0; imm_off = '0; off_sel = '0;
    shamt = '0; idx_mode = '0; sub_off = 1'b0; acc_size = '0; ld_signed = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!rsp_valid && !wb_en && byte_en == 4'd0 && eff_addr == 32'd0 && wb_value == 32'd0,
        "R1 in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after reset release
    chk(!rsp_valid && !wb_en && byte_en == 4'd0 && eff_addr == 32'd0,
        "R1 after release", eff_addr, 32'd0);
    mon_on = 1;

    drive(32'h0000_1000, 32'h0, 12'h024, 2'd0, 5'd0, 2'd0, 1'b0, 2'd0, 1'b0, 32'h4433_2211, "R2 R5 R9 offset imm byte");
    drive(32'h0000_2000, 32'h10, 12'h000, 2'd1, 5'd0, 2'd1, 1'b1, 2'd2, 1'b0, 32'hCAFE_F00D, "R3 R6 R11 pre sub word");
    drive(32'h0000_3000, 32'h3, 12'h000, 2'd2, 5'd2, 2'd2, 1'b0, 2'd2, 1'b0, 32'h1234_5678, "R4 R5 post shl");
    drive(32'hFFFF_FFF8, 32'h0, 12'h010, 2'd0, 5'd0, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0, "R7 wrap add");
    drive(32'h0000_0004, 32'h8, 12'h000, 2'd1, 5'd0, 2'd0, 1'b1, 2'd2, 1'b0, 32'h0, "R7 wrap sub");
    drive(32'h8000_0000, 32'h1, 12'h000, 2'd2, 5'd31, 2'd1, 1'b0, 2'd2, 1'b0, 32'h0, "R5 R7 shift 31");
    drive(32'h0000_0000, 32'h0, 12'hFFF, 2'd0, 5'd0, 2'd0, 1'b0, 2'd3, 1'b0, 32'h55AA_00FF, "R5 R11 imm max wide");
    idle(2);
    drive(32'h0000_4000, 32'h2, 12'h000, 2'd1, 5'd0, 2'd0, 1'b0, 2'd1, 1'b1, 32'h80F1_7F22, "R10 R12 half hi signed");
    drive(32'h0000_4000, 32'h2, 12'h000, 2'd1, 5'd0, 2'd0, 1'b0, 2'd1, 1'b0, 32'h80F1_7F22, "R10 R12 half hi unsigned");
    drive(32'h0000_4001, 32'h0, 12'h000, 2'd0, 5'd0, 2'd0, 1'b0, 2'd1, 1'b1, 32'h1234_8001, "R10 R12 half lo signed");
    drive(32'h0000_5001, 32'h0, 12'h000, 2'd0, 5'd0, 2'd0, 1'b0, 2'd0, 1'b1, 32'h8080_7F80, "R9 R12 byte1 signed");
    drive(32'h0000_5003, 32'h0, 12'h000, 2'd0, 5'd0, 2'd0, 1'b0, 2'd0, 1'b1, 32'h8080_7F80, "R9 R12 byte3 signed");
    drive(32'h0000_5002, 32'h0, 12'h000, 2'd0, 5'd0, 2'd0, 1'b0, 2'd0, 1'b0, 32'h0090_7F80, "R9 R12 byte2 unsigned");
    drive(32'h0000_6000, 32'h40, 12'h000, 2'd3, 5'd4, 2'd3, 1'b0, 2'd2, 1'b0, 32'h0, "R13 R5 reserved codes");
    drive(32'h0000_7002, 32'h0, 12'h000, 2'd0, 5'd0, 2'd1, 1'b0, 2'd2, 1'b0, 32'hDEAD_BEEF, "R11 word unaligned");
    idle(3);
    chk(sb.size() == 0, "R8 all responses seen", sb.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule